// File: doc/BRIEF.md
# LCD frame setup sequencer

This block prepares each frame for an LCD controller whose pixels live in one or two memory buffers. When a frame is requested, it reads the first halfword of the current buffer to learn the pixel depth. From that depth it works out how many palette bytes to skip and where the pixel data starts. It then checks that the whole frame fits in the buffer, applies the sub-panel line window, and hands the results to the pixel fetch logic with a single-cycle ready pulse.

On a good frame it raises the DMA condition flag for the buffer it used. In dual-buffer mode it then moves on to the other buffer. A frame too large for its buffer raises a sync fault instead, and the sequencer stops until the controller is enabled again. When the controller is enabled, the sequencer checks the buffer addresses once. If they are valid it latches both buffer bases and sizes. If not, it reports an address condition and accepts no frames.

Register fields reach the block as plain inputs. Header reads use a one-word request/response port.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, memReq, frameReady, syncFault, dmaIrq and dmaCondSet are all low and bufValid is 0.
- R2: On the first cycle that ctrlEnable is high, the address flags are checked. The flags are addrValid bit 0 for f1Top, bit 1 for f1Bottom, bit 2 for f2Top and bit 3 for f2Bottom. Bits 2 and 3 are checked only when dualMode is 1. If all checked flags are set, bufValid becomes 1 and bufIndex becomes 0 on the next cycle. Buffer 0 is latched from f1Top, and its size is f1Bottom minus f1Top. Buffer 1 is latched the same way from f2Top and f2Bottom. If a checked flag is clear, dmaCondSet bit 2 pulses in that same cycle. dmaIrq pulses with it when dmaIrqEn bit 1 is set, and bufValid stays 0.
- R3: A frameTick starts a frame only when ctrlEnable is 1, bufValid is 1, paletteMode is not 1 and the sequencer is idle. Any other tick is ignored, including one that arrives while a frame is in progress.
- R4: When paletteMode is not 2, a frame begins with one header read: memReq is held with memAddr at the base of the current buffer until memValid. Bits 14:12 of memData give the depth code: 1 is 2 bpp, 2 is 4 bpp, 3 is 8 bpp, 4 is 12 bpp and 5 is 16 bpp. Codes 0, 6 and 7 skip the frame, with neither frameReady nor syncFault.
- R5: pixelBase is the buffer base plus a skip. The skip is 0x200 for 8 bpp, 0x20 for 2 and 4 bpp, and 0 for 12 and 16 bpp. With paletteMode 2 the skip is 0, no header is read, and the depth comes from the last header captured.
- R6: The frame needs skip + (widthM1+1)*(heightM1+1)*bpp/8 bytes. If that is more than the buffer size plus 2, syncFault pulses and frameReady stays low. bufValid then drops to 0, so later ticks are ignored until the controller is enabled again. A need of exactly size plus 2 passes.
- R7: On a good frame, frameReady is high for exactly one cycle with pixelBase and pixelBits valid. In the same cycle dmaCondSet bit bufIndex pulses, and dmaIrq pulses if dmaIrqEn bit 0 is set.
- R8: With dualMode 1, bufIndex toggles after every good frame, so header reads alternate between the latched bases of buffer 0 and buffer 1. With dualMode 0, bufIndex stays 0.
- R9: With subPanelCfg bit 31 clear, lineCount is heightM1+1 and firstLine is 0. With bits 31 and 29 set, firstLine is bits 25:16 and lineCount is heightM1+1. With bit 31 set and bit 29 clear, lineCount is bits 25:16 and firstLine is 0.
- R10: When ctrlEnable goes low, bufValid is 0 from the next cycle, any frame in progress is abandoned, and ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlEnable | input | 1 | Controller enable |
| paletteMode | input | 2 | Palette handling mode (1 = no frames, 2 = no header read) |
| dualMode | input | 1 | Alternate between two buffers |
| dmaIrqEn | input | 2 | DMA interrupt enables: bit 0 frame done, bit 1 bad address |
| f1Top | input | ADDR_W | Buffer 0 start address |
| f1Bottom | input | ADDR_W | Buffer 0 end address |
| f2Top | input | ADDR_W | Buffer 1 start address |
| f2Bottom | input | ADDR_W | Buffer 1 end address |
| addrValid | input | 4 | Validity of f1Top, f1Bottom, f2Top, f2Bottom (bits 0 to 3) |
| widthM1 | input | DIM_W | Panel width minus one |
| heightM1 | input | DIM_W | Panel height minus one |
| subPanelCfg | input | 32 | Sub-panel window word |
| frameTick | input | 1 | Frame start request |
| memReq | output | 1 | Header read request |
| memAddr | output | ADDR_W | Header read address |
| memValid | input | 1 | Header read response valid |
| memData | input | 16 | Header read data |
| frameReady | output | 1 | One-cycle pulse: frame results valid |
| pixelBase | output | ADDR_W | Start address of pixel data |
| pixelBits | output | 5 | Bits per pixel |
| lineCount | output | DIM_W+1 | Number of lines to display |
| firstLine | output | DIM_W | First displayed line |
| bufIndex | output | 1 | Current buffer index |
| bufValid | output | 1 | Buffer index is valid |
| dmaCondSet | output | 3 | DMA condition set pulses: bit 0/1 buffer done, bit 2 bad address |
| dmaIrq | output | 1 | DMA interrupt pulse |
| syncFault | output | 1 | Frame-too-large pulse |

## Verification
The assertions assume that memValid is high only while memReq is asserted. They also assume that buffer addresses, address flags and dualMode stay steady from the enable cycle until the next disable, and that each bottom address is at or above its top address. The bench holds to this in two ways. It changes buffer and mode settings only while ctrlEnable is low, and it changes panel geometry only while the sequencer is idle. It also answers each header request in the cycle after it first appears, and drops memValid as soon as the request goes away.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_READ,
    ST_CHECK,
    ST_DONE,
    ST_ERROR
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadBases;
    logic capHdr;
    logic capResult;
    logic flipIdx;
  } dpStrobe_t;

endpackage

// File: rtl/lcd_depth_decode.sv
module lcd_depth_decode #(
  parameter int OFF_W      = 10,
  parameter int FULL_SKIP  = 'h200,
  parameter int SMALL_SKIP = 'h20
) (
  input  logic [2:0]       depthCode,
  output logic [4:0]       bitsPerPixel,
  output logic [OFF_W-1:0] paletteSkip,
  output logic             supported
);

  always_comb begin
    bitsPerPixel = 5'd0;
    paletteSkip  = '0;
    supported    = 1'b1;
    unique case (depthCode)
      3'd1: begin bitsPerPixel = 5'd2;  paletteSkip = OFF_W'(SMALL_SKIP); end
      3'd2: begin bitsPerPixel = 5'd4;  paletteSkip = OFF_W'(SMALL_SKIP); end
      3'd3: begin bitsPerPixel = 5'd8;  paletteSkip = OFF_W'(FULL_SKIP);  end
      3'd4: bitsPerPixel = 5'd12;
      3'd5: bitsPerPixel = 5'd16;
      default: supported = 1'b0;
    endcase
  end

endmodule

// File: rtl/lcd_frame_dp.sv
module lcd_frame_dp
  import lcd_frame_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DIM_W      = 10,
  parameter int FULL_SKIP  = 'h200,
  parameter int SMALL_SKIP = 'h20,
  parameter int SLACK      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic [1:0]        paletteMode,
  input  logic [ADDR_W-1:0] f1Top,
  input  logic [ADDR_W-1:0] f1Bottom,
  input  logic [ADDR_W-1:0] f2Top,
  input  logic [ADDR_W-1:0] f2Bottom,
  input  logic [DIM_W-1:0]  widthM1,
  input  logic [DIM_W-1:0]  heightM1,
  input  logic [31:0]       subPanelCfg,
  input  logic [15:0]       memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              depthOk,
  output logic              fitsOk,
  output logic              bufIndex,
  output logic [ADDR_W-1:0] pixelBase,
  output logic [4:0]        pixelBits,
  output logic [DIM_W:0]    lineCount,
  output logic [DIM_W-1:0]  firstLine
);

  localparam int NUM_BUF = 2;
  localparam int OFF_W   = $clog2(FULL_SKIP + 1) + 1;
  localparam int PROD_W  = 2 * (DIM_W + 1) + 5;
  localparam int CALC_W  = ((PROD_W > ADDR_W) ? PROD_W : ADDR_W) + 2;
  localparam int SUB_LSB = 16;
  localparam int SUB_ON  = 31;
  localparam int SUB_FST = 29;

  logic [ADDR_W-1:0] topIn  [NUM_BUF];
  logic [ADDR_W-1:0] botIn  [NUM_BUF];
  logic [ADDR_W-1:0] bufTop [NUM_BUF];
  logic [ADDR_W-1:0] bufSize[NUM_BUF];

  assign topIn[0] = f1Top;
  assign topIn[1] = f2Top;
  assign botIn[0] = f1Bottom;
  assign botIn[1] = f2Bottom;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bufTop[b]  <= '0;
        bufSize[b] <= '0;
      end else if (strb.loadBases) begin
        bufTop[b]  <= topIn[b];
        bufSize[b] <= botIn[b] - topIn[b];
      end
    end
  end

  // buffer index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              bufIndex <= 1'b0;
    else if (strb.loadBases) bufIndex <= 1'b0;
    else if (strb.flipIdx)   bufIndex <= ~bufIndex;
  end

  assign memAddr = bufTop[bufIndex];

  // header word: only the depth field is kept
  logic [2:0] hdrDepth;
  logic       unusedHdrBits;
  assign unusedHdrBits = ^{memData[15], memData[11:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hdrDepth <= 3'd0;
    else if (strb.capHdr) hdrDepth <= memData[14:12];
  end

  logic [4:0]       decBits;
  logic [OFF_W-1:0] decSkip;
  logic [OFF_W-1:0] skipBytes;

  lcd_depth_decode #(
    .OFF_W     (OFF_W),
    .FULL_SKIP (FULL_SKIP),
    .SMALL_SKIP(SMALL_SKIP)
  ) u_decode (
    .depthCode   (hdrDepth),
    .bitsPerPixel(decBits),
    .paletteSkip (decSkip),
    .supported   (depthOk)
  );

  assign skipBytes = (paletteMode == 2'd2) ? '0 : decSkip;

  // frame size check
  logic [DIM_W:0]    panelWidth;
  logic [DIM_W:0]    panelHeight;
  logic [CALC_W-1:0] pixProduct;
  logic [CALC_W-1:0] needBytes;
  logic [CALC_W-1:0] limitBytes;

  assign panelWidth  = {1'b0, widthM1} + 1'b1;
  assign panelHeight = {1'b0, heightM1} + 1'b1;
  assign pixProduct  = CALC_W'(panelWidth) * CALC_W'(panelHeight) * CALC_W'(decBits);
  assign needBytes   = CALC_W'(skipBytes) + (pixProduct >> 3);
  assign limitBytes  = CALC_W'(bufSize[bufIndex]) + CALC_W'(SLACK);
  assign fitsOk      = (needBytes <= limitBytes);

  // sub-panel window
  logic [DIM_W-1:0] subLine;
  logic [DIM_W:0]   nextLines;
  logic [DIM_W-1:0] nextFirst;
  logic             unusedSubBits;

  assign subLine       = subPanelCfg[SUB_LSB +: DIM_W];
  assign unusedSubBits = ^{subPanelCfg[30], subPanelCfg[28:SUB_LSB+DIM_W], subPanelCfg[SUB_LSB-1:0]};

  always_comb begin
    nextLines = panelHeight;
    nextFirst = '0;
    if (subPanelCfg[SUB_ON]) begin
      if (subPanelCfg[SUB_FST]) nextFirst = subLine;
      else                      nextLines = {1'b0, subLine};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixelBase <= '0;
      pixelBits <= '0;
      lineCount <= '0;
      firstLine <= '0;
    end else if (strb.capResult) begin
      pixelBase <= bufTop[bufIndex] + ADDR_W'(skipBytes);
      pixelBits <= decBits;
      lineCount <= nextLines;
      firstLine <= nextFirst;
    end
  end

  // R8: each flip strobe changes the buffer index
  p_flip_toggles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flipIdx |=> (bufIndex != $past(bufIndex)));

  // R2: loading the bases selects buffer 0 at the frame-1 top address
  p_load_selects_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadBases |=> ((bufIndex == 1'b0) && (memAddr == $past(f1Top))));

endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcd_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrlEnable,
  input  logic [1:0] paletteMode,
  input  logic       dualMode,
  input  logic [1:0] dmaIrqEn,
  input  logic [3:0] addrValid,
  input  logic       frameTick,
  input  logic       memValid,
  input  logic       depthOk,
  input  logic       fitsOk,
  input  logic       bufIndex,
  output dpStrobe_t  strb,
  output logic       memReq,
  output logic       frameReady,
  output logic       syncFault,
  output logic [2:0] dmaCondSet,
  output logic       dmaIrq,
  output logic       bufValid
);

  seqState_t state, nextState;
  logic      enPrev;
  logic      enRise;
  logic      addrOk;
  logic      startOk;

  assign enRise  = ctrlEnable && !enPrev;
  assign addrOk  = addrValid[0] && addrValid[1] &&
                   (!dualMode || (addrValid[2] && addrValid[3]));
  assign startOk = frameTick && ctrlEnable && bufValid && (paletteMode != 2'd1);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (startOk) nextState = (paletteMode == 2'd2) ? ST_CHECK : ST_HDR_READ;
      ST_HDR_READ: if (memValid) nextState = ST_CHECK;
      ST_CHECK: begin
        if (!depthOk)     nextState = ST_IDLE;
        else if (!fitsOk) nextState = ST_ERROR;
        else              nextState = ST_DONE;
      end
      default:            nextState = ST_IDLE;
    endcase
    if (!ctrlEnable) nextState = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      enPrev   <= 1'b0;
      bufValid <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= ctrlEnable;
      if (!ctrlEnable || state == ST_ERROR) bufValid <= 1'b0;
      else if (enRise && addrOk)            bufValid <= 1'b1;
    end
  end

  always_comb begin
    strb.loadBases = enRise && addrOk;
    strb.capHdr    = (state == ST_HDR_READ) && memValid;
    strb.capResult = (state == ST_CHECK);
    strb.flipIdx   = (state == ST_DONE) && dualMode;
  end

  assign memReq     = (state == ST_HDR_READ);
  assign frameReady = (state == ST_DONE);
  assign syncFault  = (state == ST_ERROR);

  always_comb begin
    dmaCondSet    = 3'b000;
    dmaCondSet[0] = frameReady && !bufIndex;
    dmaCondSet[1] = frameReady && bufIndex;
    dmaCondSet[2] = enRise && !addrOk;
    dmaIrq        = (frameReady && dmaIrqEn[0]) || (dmaCondSet[2] && dmaIrqEn[1]);
  end

  // R4: a header request needs a valid buffer
  p_req_needs_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> bufValid);

  // R3: a header read starts only from a legal tick
  p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && $past(state == ST_IDLE)) |->
      $past(frameTick && ctrlEnable && paletteMode != 2'd1));

  // R6: a fault follows a failed fit check on a supported depth
  p_fault_after_misfit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    syncFault |-> $past(!fitsOk && depthOk));

  // R7: a ready pulse follows a passing fit check and lasts one cycle
  p_ready_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frameReady |-> ($past(fitsOk && depthOk) && !$past(frameReady)));

  // R7: at most one condition bit per cycle
  p_cond_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dmaCondSet));

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_frame_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlEnable,
  input  logic [1:0]        paletteMode,
  input  logic              dualMode,
  input  logic [1:0]        dmaIrqEn,
  input  logic [ADDR_W-1:0] f1Top,
  input  logic [ADDR_W-1:0] f1Bottom,
  input  logic [ADDR_W-1:0] f2Top,
  input  logic [ADDR_W-1:0] f2Bottom,
  input  logic [3:0]        addrValid,
  input  logic [DIM_W-1:0]  widthM1,
  input  logic [DIM_W-1:0]  heightM1,
  input  logic [31:0]       subPanelCfg,
  input  logic              frameTick,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [15:0]       memData,
  output logic              frameReady,
  output logic [ADDR_W-1:0] pixelBase,
  output logic [4:0]        pixelBits,
  output logic [DIM_W:0]    lineCount,
  output logic [DIM_W-1:0]  firstLine,
  output logic              bufIndex,
  output logic              bufValid,
  output logic [2:0]        dmaCondSet,
  output logic              dmaIrq,
  output logic              syncFault
);

  dpStrobe_t strb;
  logic      depthOk;
  logic      fitsOk;

  lcd_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlEnable (ctrlEnable),
    .paletteMode(paletteMode),
    .dualMode   (dualMode),
    .dmaIrqEn   (dmaIrqEn),
    .addrValid  (addrValid),
    .frameTick  (frameTick),
    .memValid   (memValid),
    .depthOk    (depthOk),
    .fitsOk     (fitsOk),
    .bufIndex   (bufIndex),
    .strb       (strb),
    .memReq     (memReq),
    .frameReady (frameReady),
    .syncFault  (syncFault),
    .dmaCondSet (dmaCondSet),
    .dmaIrq     (dmaIrq),
    .bufValid   (bufValid)
  );

  lcd_frame_dp #(
    .ADDR_W(ADDR_W),
    .DIM_W (DIM_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .paletteMode(paletteMode),
    .f1Top      (f1Top),
    .f1Bottom   (f1Bottom),
    .f2Top      (f2Top),
    .f2Bottom   (f2Bottom),
    .widthM1    (widthM1),
    .heightM1   (heightM1),
    .subPanelCfg(subPanelCfg),
    .memData    (memData),
    .memAddr    (memAddr),
    .depthOk    (depthOk),
    .fitsOk     (fitsOk),
    .bufIndex   (bufIndex),
    .pixelBase  (pixelBase),
    .pixelBits  (pixelBits),
    .lineCount  (lineCount),
    .firstLine  (firstLine)
  );

endmodule

// File: tb/lcd_frame_seq_bench.sv
`timescale 1ns/1ps
module lcd_frame_seq_bench;

  localparam int ADDR_W = 32;
  localparam int DIM_W  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctrlEnable = 1'b0;
  logic [1:0]        paletteMode = 2'd0;
  logic              dualMode = 1'b0;
  logic [1:0]        dmaIrqEn = 2'b00;
  logic [ADDR_W-1:0] f1Top = 32'h1000_0000;
  logic [ADDR_W-1:0] f1Bottom = 32'h1000_1000;
  logic [ADDR_W-1:0] f2Top = 32'h2000_0400;
  logic [ADDR_W-1:0] f2Bottom = 32'h2000_1400;
  logic [3:0]        addrValid = 4'hF;
  logic [DIM_W-1:0]  widthM1 = 10'd7;
  logic [DIM_W-1:0]  heightM1 = 10'd3;
  logic [31:0]       subPanelCfg = 32'h0;
  logic              frameTick = 1'b0;
  logic              memValid = 1'b0;
  logic [15:0]       memData = 16'h0;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              frameReady;
  logic [ADDR_W-1:0] pixelBase;
  logic [4:0]        pixelBits;
  logic [DIM_W:0]    lineCount;
  logic [DIM_W-1:0]  firstLine;
  logic              bufIndex;
  logic              bufValid;
  logic [2:0]        dmaCondSet;
  logic              dmaIrq;
  logic              syncFault;

  always #2.5 clk = ~clk;

  lcd_frame_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_lcd_frame_seq (
    .clk(clk), .rst_n(rst_n), .ctrlEnable(ctrlEnable), .paletteMode(paletteMode),
    .dualMode(dualMode), .dmaIrqEn(dmaIrqEn), .f1Top(f1Top), .f1Bottom(f1Bottom),
    .f2Top(f2Top), .f2Bottom(f2Bottom), .addrValid(addrValid), .widthM1(widthM1),
    .heightM1(heightM1), .subPanelCfg(subPanelCfg), .frameTick(frameTick),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .frameReady(frameReady), .pixelBase(pixelBase), .pixelBits(pixelBits),
    .lineCount(lineCount), .firstLine(firstLine), .bufIndex(bufIndex),
    .bufValid(bufValid), .dmaCondSet(dmaCondSet), .dmaIrq(dmaIrq), .syncFault(syncFault)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bppOf(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 12;
      5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int skipOf(input int code);
    if (code == 3) return 'h200;
    if (code == 1 || code == 2) return 'h20;
    return 0;
  endfunction

  // results of one frame run
  int                nReady, nFault, nReq, nIrq;
  logic [ADDR_W-1:0] capBase, reqAddr;
  logic [4:0]        capBits;
  logic [DIM_W:0]    capLines;
  logic [DIM_W-1:0]  capFirst;
  logic [2:0]        capCond;

  task automatic runFrame(input logic [15:0] hdr, input bit busyTick);
    nReady = 0; nFault = 0; nReq = 0; nIrq = 0;
    capBase = '0; reqAddr = '0; capBits = '0; capLines = '0; capFirst = '0; capCond = '0;
    @(negedge clk);
    frameTick = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      frameTick = 1'b0;
      memValid  = 1'b0;
      if (memReq) begin
        nReq++;
        reqAddr  = memAddr;
        memValid = 1'b1;
        memData  = hdr;
        if (busyTick) frameTick = 1'b1;
      end
      if (frameReady) begin
        nReady++;
        capBase  = pixelBase;
        capBits  = pixelBits;
        capLines = lineCount;
        capFirst = firstLine;
        capCond  = dmaCondSet;
        if (busyTick) frameTick = 1'b1;
      end
      if (dmaIrq) nIrq++;
      if (syncFault) nFault++;
    end
    frameTick = 1'b0;
    memValid  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // disable, then enable; capture enable-cycle pulses
  logic [2:0] enCond;
  logic       enIrq;
  task automatic reEnable(input bit dual, input logic [3:0] valid);
    @(negedge clk);
    ctrlEnable = 1'b0;
    @(negedge clk);
    dualMode  = dual;
    addrValid = valid;
    @(negedge clk);
    ctrlEnable = 1'b1;
    #1;
    enCond = dmaCondSet;
    enIrq  = dmaIrq;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "memReq", memReq, 0);
    chk("R1", "frameReady", frameReady, 0);
    chk("R1", "bufValid", bufValid, 0);
    chk("R1", "dmaCondSet", dmaCondSet, 0);
    chk("R1", "syncFault/irq", {syncFault, dmaIrq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 invalid f1 bottom
    dmaIrqEn = 2'b10;
    reEnable(1'b0, 4'b1101);
    chk("R2", "bad addr cond", enCond, 3'b100);
    chk("R2", "bad addr irq", enIrq, 1);
    chk("R2", "bufValid stays 0", bufValid, 0);
    runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
    chk("R2", "tick without buffer req", nReq, 0);
    chk("R3", "tick without buffer ready", nReady, 0);

    // R2 dual with f2 invalid, irq disabled
    dmaIrqEn = 2'b00;
    reEnable(1'b1, 4'b0111);
    chk("R2", "dual bad f2 cond", enCond, 3'b100);
    chk("R2", "dual bad f2 no irq", enIrq, 0);

    // R2 single mode ignores f2 flags
    reEnable(1'b0, 4'b0011);
    chk("R2", "single good cond", enCond, 3'b000);
    chk("R2", "single bufValid", bufValid, 1);
    chk("R2", "single index", bufIndex, 0);
    chk("R2", "base at f1Top", memAddr, f1Top);

    // R4 R5 R7: sweep all depth codes, palette mode 0
    for (int code = 0; code < 8; code++) begin
      dmaIrqEn = {1'b0, code[0]};
      runFrame(16'((code << 12) | 16'h8A5), 1'b0);
      chk("R4", $sformatf("code %0d header req", code), nReq, 1);
      chk("R4", $sformatf("code %0d req addr", code), reqAddr, f1Top);
      chk("R4", $sformatf("code %0d fault", code), nFault, 0);
      if (bppOf(code) == 0) begin
        chk("R4", $sformatf("code %0d skipped", code), nReady, 0);
      end else begin
        chk("R7", $sformatf("code %0d one ready", code), nReady, 1);
        chk("R4", $sformatf("code %0d bits", code), capBits, bppOf(code));
        chk("R5", $sformatf("code %0d base", code), capBase, f1Top + skipOf(code));
        chk("R7", $sformatf("code %0d cond", code), capCond, 3'b001);
        chk("R7", $sformatf("code %0d irq", code), nIrq, code % 2);
        chk("R8", "single index held", bufIndex, 0);
      end
    end

    // R5 palette mode 2 uses the last header with no skip
    runFrame({1'b0, 3'd3, 12'h0}, 1'b0);
    paletteMode = 2'd2;
    runFrame({1'b0, 3'd1, 12'h0}, 1'b0);
    chk("R5", "mode2 no header read", nReq, 0);
    chk("R5", "mode2 ready", nReady, 1);
    chk("R5", "mode2 bits from old header", capBits, 8);
    chk("R5", "mode2 base no skip", capBase, f1Top);

    // R3 palette mode 1 ignores ticks
    paletteMode = 2'd1;
    runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
    chk("R3", "mode1 req", nReq, 0);
    chk("R3", "mode1 ready", nReady, 0);
    paletteMode = 2'd0;

    // R3 ticks while busy are ignored
    runFrame({1'b0, 3'd4, 12'h0}, 1'b1);
    chk("R3", "busy tick one req", nReq, 1);
    chk("R3", "busy tick one ready", nReady, 1);

    // R9 sub-panel window
    heightM1 = 10'd5;
    subPanelCfg = 32'h0123_0000;
    runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
    chk("R9", "off lines", capLines, 6);
    chk("R9", "off first", capFirst, 0);
    subPanelCfg = 32'hA123_0000;
    runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
    chk("R9", "first-mode lines", capLines, 6);
    chk("R9", "first-mode first", capFirst, 10'h123);
    subPanelCfg = 32'h8045_0000;
    runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
    chk("R9", "count-mode lines", capLines, 10'h045);
    chk("R9", "count-mode first", capFirst, 0);
    subPanelCfg = 32'h0;

    // R6 fit boundary, 16 bpp, width 8, size 62
    f1Bottom = f1Top + 62;
    reEnable(1'b0, 4'b0011);
    for (int h = 1; h <= 6; h++) begin
      heightM1 = 10'(h - 1);
      runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
      if (16 * h <= 64) begin
        chk("R6", $sformatf("h %0d fits", h), {nReady, nFault}, {32'd1, 32'd0});
      end else begin
        chk("R6", $sformatf("h %0d fault", h), {nReady, nFault}, {32'd0, 32'd1});
        chk("R6", "bufValid dropped", bufValid, 0);
        runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
        chk("R6", "ticks ignored after fault", nReq, 0);
        heightM1 = 10'd0;
        reEnable(1'b0, 4'b0011);
      end
    end
    // 2 bpp with 0x20 skip: need 32 + 2*h against 64
    heightM1 = 10'd15;
    runFrame({1'b0, 3'd1, 12'h0}, 1'b0);
    chk("R6", "2bpp exact limit passes", {nReady, nFault}, {32'd1, 32'd0});
    heightM1 = 10'd16;
    runFrame({1'b0, 3'd1, 12'h0}, 1'b0);
    chk("R6", "2bpp over limit faults", {nReady, nFault}, {32'd0, 32'd1});
    heightM1 = 10'd3;

    // R8 dual buffers alternate
    f1Bottom = f1Top + 32'h1000;
    dmaIrqEn = 2'b01;
    reEnable(1'b1, 4'b1111);
    chk("R8", "dual enable ok", bufValid, 1);
    for (int k = 0; k < 4; k++) begin
      runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
      chk("R8", $sformatf("dual frame %0d addr", k), reqAddr, (k % 2 == 0) ? f1Top : f2Top);
      chk("R8", $sformatf("dual frame %0d cond", k), capCond, (k % 2 == 0) ? 3'b001 : 3'b010);
      chk("R7", $sformatf("dual frame %0d irq", k), nIrq, 1);
      chk("R8", $sformatf("dual frame %0d base", k), capBase, (k % 2 == 0) ? f1Top : f2Top);
    end

    // R10 disable invalidates and ignores ticks
    @(negedge clk);
    ctrlEnable = 1'b0;
    @(negedge clk);
    chk("R10", "bufValid after disable", bufValid, 0);
    runFrame({1'b0, 3'd5, 12'h0}, 1'b0);
    chk("R10", "disabled tick", {nReq, nReady}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule